// File: doc/BRIEF.md
# Pulse-Synchronized Primary Gate Controller

This block drives the gate of a primary power switch from edge events that are relayed across an isolation barrier from the regulating side. A turn-on event and a turn-off event each arrive as a separate single-cycle strobe. The gate is a set/reset latch that these strobes control. A tick-based timer limits how long the gate may stay high. The limit is short while the converter is still in its soft-start phase and longer once regulation has been handed over. An overcurrent comparator output can force the gate low at any time.

The same strobe path also carries a shutdown command. A run of three turn-off strobes, with no accepted turn-on strobe between them, arms a delay timer. When the delay expires, a latched shutdown request is raised and the gate is held low until reset. All timing is counted in ticks of a 1 MHz strobe input. The ON-time limits and the shutdown delay are parameters, so a simulation can shorten them.

Top module: `pulse_gate_ctrl`

## Requirements
- R1: With enable high, overcurrent low and no shutdown, a cycle with posPulse high and negPulse low drives gateOn high one clock later.
- R2: A cycle with negPulse high drives gateOn low one clock later. This holds even when posPulse is high in the same cycle.
- R3: With regMode low (soft-start), gateOn falls on the clock after the 19th tick counted while it is high, so exactly 19 ticks are seen during the ON period.
- R4: With regMode high (regulated), the ON-time limit is 25 ticks, with the same counting as R3. The gate is never high for more than 25 ticks.
- R5: While ocTrip is high, gateOn is low from the next clock on. A posPulse in a cycle with ocTrip high is ignored: it neither sets the gate nor breaks a run of turn-off strobes.
- R6: Three accepted negPulse cycles with no accepted posPulse between them form a shutdown command. An accepted posPulse resets the run count to zero.
- R7: shutdownReq rises one clock after the tick that completes SHDN_DELAY_TICKS ticks counted after the command. Turn-off strobes that arrive during the delay neither restart it nor extend it.
- R8: Once shutdownReq is high, it stays high and gateOn stays low until rstN is asserted. posPulse has no effect on either.
- R9: While enable is low, gateOn is held low and strobes are not counted toward a shutdown command.
- R10: While rstN is low, gateOn and shutdownReq are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows gate switching and command decoding |
| tick | input | 1 | One-cycle strobe at 1 MHz; the time base for all limits |
| regMode | input | 1 | 0 = soft-start limit, 1 = regulated limit |
| posPulse | input | 1 | Decoded turn-on edge strobe |
| negPulse | input | 1 | Decoded turn-off edge strobe |
| ocTrip | input | 1 | Overcurrent comparator output |
| gateOn | output | 1 | Primary switch gate drive |
| shutdownReq | output | 1 | Latched shutdown request |

## Verification
The hardest case to reach from the ports is a turn-on strobe that lands while overcurrent is active, in the middle of a turn-off run. The strobe must not reset the run, and only a later third turn-off shows whether it was discarded. A directed sequence builds this case exactly and then measures the tick count up to shutdownReq. A second directed run injects an extra turn-off strobe partway through the shutdown delay, to show that the delay is not restarted. Seeded random traffic adds overlapping strobes, overcurrent and mode changes, and a bench reference model checks every cycle against it.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic gateSet;   // latch the gate high
    logic gateClr;   // force the gate low (wins over gateSet)
    logic delayArm;  // clear the shutdown delay counter
    logic delayRun;  // let the delay counter advance on ticks
  } pgcStrobe_t;

  typedef enum logic [1:0] {
    SD_IDLE  = 2'd0,
    SD_ARMED = 2'd1,
    SD_SHUT  = 2'd2
  } sdState_t;

endpackage

// File: rtl/pgc_datapath.sv
module pgc_datapath
  import pgc_pkg::*;
#(
  parameter int SS_MAX_TICKS      = 19,
  parameter int REG_MAX_TICKS     = 25,
  parameter int SHDN_DELAY_TICKS  = 200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regMode,
  input  pgcStrobe_t strb,
  output logic       gateOn,
  output logic       onLimitHit,
  output logic       delayDone
);

  localparam int ON_MAX = (REG_MAX_TICKS > SS_MAX_TICKS) ? REG_MAX_TICKS : SS_MAX_TICKS;
  localparam int ON_W   = $clog2(ON_MAX + 1);
  localparam int DLY_W  = $clog2(SHDN_DELAY_TICKS + 1);

  localparam logic [ON_W-1:0]  SS_LIM  = ON_W'(SS_MAX_TICKS);
  localparam logic [ON_W-1:0]  REG_LIM = ON_W'(REG_MAX_TICKS);
  localparam logic [ON_W-1:0]  ON_TOP  = ON_W'(ON_MAX);
  localparam logic [DLY_W-1:0] DLY_END = DLY_W'(SHDN_DELAY_TICKS);

  logic [ON_W-1:0]  onTimer;
  logic [DLY_W-1:0] delayCnt;
  logic [ON_W-1:0]  activeLim;

  // Gate latch: clear dominates set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             gateOn <= 1'b0;
    else if (strb.gateClr) gateOn <= 1'b0;
    else if (strb.gateSet) gateOn <= 1'b1;
  end

  // ON-time counter, runs only while the gate is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          onTimer <= '0;
    else if (!gateOn)                   onTimer <= '0;
    else if (tick && onTimer != ON_TOP) onTimer <= onTimer + 1'b1;
  end

  assign activeLim  = regMode ? REG_LIM : SS_LIM;
  assign onLimitHit = gateOn && (onTimer >= activeLim);

  // Shutdown delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 delayCnt <= '0;
    else if (strb.delayArm)                    delayCnt <= '0;
    else if (strb.delayRun && tick && !delayDone) delayCnt <= delayCnt + 1'b1;
  end

  assign delayDone = strb.delayRun && (delayCnt == DLY_END);

endmodule

// File: rtl/pgc_control.sv
module pgc_control
  import pgc_pkg::*;
#(
  parameter int NEG_RUN_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       posPulse,
  input  logic       negPulse,
  input  logic       ocTrip,
  input  logic       onLimitHit,
  input  logic       delayDone,
  output pgcStrobe_t strb,
  output logic       shutdownReq
);

  localparam int RUN_W = (NEG_RUN_LEN > 2) ? $clog2(NEG_RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(NEG_RUN_LEN - 1);

  sdState_t         sdState;
  logic [RUN_W-1:0] negRun;
  logic             isShut;
  logic             posOk;
  logic             negOk;
  logic             cmdSeen;

  assign isShut  = (sdState == SD_SHUT);
  assign posOk   = posPulse && enable && !ocTrip && !isShut;
  assign negOk   = negPulse && enable && !isShut;
  assign cmdSeen = (sdState == SD_IDLE) && negOk && !posOk && (negRun == RUN_LAST);

  always_comb begin
    strb.gateSet  = posOk;
    strb.gateClr  = !enable || isShut || ocTrip || negPulse || onLimitHit || delayDone;
    strb.delayArm = cmdSeen;
    strb.delayRun = (sdState == SD_ARMED);
  end

  // Consecutive turn-off run counter, active only before a command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      negRun <= '0;
    else if (sdState != SD_IDLE)    negRun <= '0;
    else if (posOk)                 negRun <= '0;
    else if (negOk) begin
      if (negRun == RUN_LAST)       negRun <= '0;
      else                          negRun <= negRun + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdState <= SD_IDLE;
    else begin
      case (sdState)
        SD_IDLE:  if (cmdSeen)   sdState <= SD_ARMED;
        SD_ARMED: if (delayDone) sdState <= SD_SHUT;
        default:                 sdState <= SD_SHUT;
      endcase
    end
  end

  assign shutdownReq = isShut;

endmodule

// File: rtl/pulse_gate_ctrl.sv
module pulse_gate_ctrl #(
  parameter int SS_MAX_TICKS     = 19,
  parameter int REG_MAX_TICKS    = 25,
  parameter int SHDN_DELAY_TICKS = 200000,
  parameter int NEG_RUN_LEN      = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic tick,
  input  logic regMode,
  input  logic posPulse,
  input  logic negPulse,
  input  logic ocTrip,
  output logic gateOn,
  output logic shutdownReq
);

  pgc_pkg::pgcStrobe_t strb;
  logic onLimitHit;
  logic delayDone;

  pgc_control #(
    .NEG_RUN_LEN(NEG_RUN_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .posPulse   (posPulse),
    .negPulse   (negPulse),
    .ocTrip     (ocTrip),
    .onLimitHit (onLimitHit),
    .delayDone  (delayDone),
    .strb       (strb),
    .shutdownReq(shutdownReq)
  );

  pgc_datapath #(
    .SS_MAX_TICKS    (SS_MAX_TICKS),
    .REG_MAX_TICKS   (REG_MAX_TICKS),
    .SHDN_DELAY_TICKS(SHDN_DELAY_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .regMode   (regMode),
    .strb      (strb),
    .gateOn    (gateOn),
    .onLimitHit(onLimitHit),
    .delayDone (delayDone)
  );

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int SS_MAX_TICKS  = 19,
  parameter int REG_MAX_TICKS = 25
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic tick,
  input logic posPulse,
  input logic negPulse,
  input logic ocTrip,
  input logic gateOn,
  input logic shutdownReq
);

  localparam int ON_MAX = (REG_MAX_TICKS > SS_MAX_TICKS) ? REG_MAX_TICKS : SS_MAX_TICKS;
  localparam int CW     = $clog2(ON_MAX + 3);

  logic [CW-1:0] onCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        onCnt <= '0;
    else if (!gateOn) onCnt <= '0;
    else if (tick && onCnt != {CW{1'b1}}) onCnt <= onCnt + 1'b1;
  end

  p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(posPulse));

  p_neg_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    negPulse |=> !gateOn);

  p_on_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> (onCnt <= CW'(ON_MAX)));

  p_oc_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    ocTrip |=> !gateOn);

  p_shut_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> shutdownReq);

  p_shut_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> !gateOn);

  p_disable_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gateOn);

endmodule

bind pulse_gate_ctrl pgc_checker #(
  .SS_MAX_TICKS (SS_MAX_TICKS),
  .REG_MAX_TICKS(REG_MAX_TICKS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .tick       (tick),
  .posPulse   (posPulse),
  .negPulse   (negPulse),
  .ocTrip     (ocTrip),
  .gateOn     (gateOn),
  .shutdownReq(shutdownReq)
);

// File: tb/pulse_gate_ctrl_test.sv
`timescale 1ns/1ps
module pulse_gate_ctrl_test;

  localparam int SS_T   = 19;
  localparam int REG_T  = 25;
  localparam int DLY_T  = 50;
  localparam int RUN_N  = 3;
  localparam int ON_TOP = (REG_T > SS_T) ? REG_T : SS_T;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic tick = 1'b0;
  logic regMode = 1'b0;
  logic posPulse = 1'b0;
  logic negPulse = 1'b0;
  logic ocTrip = 1'b0;
  logic gateOn;
  logic shutdownReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int tickPh = 0;

  always #5 clk = ~clk;

  pulse_gate_ctrl #(
    .SS_MAX_TICKS(SS_T), .REG_MAX_TICKS(REG_T),
    .SHDN_DELAY_TICKS(DLY_T), .NEG_RUN_LEN(RUN_N)
  ) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .regMode(regMode),
    .posPulse(posPulse), .negPulse(negPulse), .ocTrip(ocTrip),
    .gateOn(gateOn), .shutdownReq(shutdownReq)
  );

  // 1 MHz-style tick, compressed to one in four clocks
  always @(posedge clk) begin
    tickPh <= (tickPh + 1) % 4;
    tick   <= (tickPh == 3);
  end

  // Reference model built from the requirements
  bit mGate, mArmed, mShut;
  int mOn, mDly, mRun;

  function automatic int onLimit(input bit reg_m);
    return reg_m ? REG_T : SS_T;
  endfunction

  always @(posedge clk) begin
    bit hit, posOk, negOk, doneNow, nGate;
    int nOn;
    if (!rstN) begin
      mGate = 0; mArmed = 0; mShut = 0; mOn = 0; mDly = 0; mRun = 0;
    end else begin
      hit     = mGate && (mOn >= onLimit(regMode));
      posOk   = posPulse && enable && !ocTrip && !mShut;
      negOk   = negPulse && enable && !mShut;
      doneNow = mArmed && (mDly == DLY_T);
      nOn = !mGate ? 0 : ((tick && mOn != ON_TOP) ? mOn + 1 : mOn);
      if (!enable || mShut || ocTrip || negPulse || hit || doneNow) nGate = 0;
      else if (posOk) nGate = 1;
      else nGate = mGate;
      if (!mArmed && !mShut) begin
        if (posOk) mRun = 0;
        else if (negOk) begin
          if (mRun == RUN_N - 1) begin mArmed = 1; mDly = 0; mRun = 0; end
          else mRun++;
        end
      end else if (mArmed) begin
        if (doneNow) begin mArmed = 0; mShut = 1; end
        else if (tick) mDly++;
      end
      mGate = nGate;
      mOn   = nOn;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1/R2/R3/R4/R5/R9", "gate vs model", int'(gateOn), int'(mGate));
      check("R6/R7/R8", "shutdown vs model", int'(shutdownReq), int'(mShut));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit p, input bit n);
    posPulse = p; negPulse = n;
    @(negedge clk);
    posPulse = 0; negPulse = 0;
  endtask

  task automatic doReset();
    rstN = 0; posPulse = 0; negPulse = 0; ocTrip = 0; enable = 1; regMode = 0;
    step(3);
    rstN = 1;
    step(2);
  endtask

  task automatic measureOn(output int n);
    n = 0;
    for (int i = 0; i < 1000 && gateOn; i++) begin
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic measureShut(input bit injectNeg, output int n);
    n = 0;
    for (int i = 0; i < 2000 && !shutdownReq; i++) begin
      if (tick) n++;
      negPulse = (injectNeg && (i == 40 || i == 41 || i == 90));
      @(negedge clk);
    end
    negPulse = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_c0de));
    rstN = 0;
    step(2);
    check("R10", "gate in reset", int'(gateOn), 0);
    check("R10", "shutdown in reset", int'(shutdownReq), 0);
    doReset();

    // R1 / R3: soft-start cap
    regMode = 0;
    pulse(1, 0);
    check("R1", "gate after turn-on", int'(gateOn), 1);
    measureOn(n);
    check("R3", "soft-start ON ticks", n, SS_T);

    // R4: regulated cap
    regMode = 1;
    pulse(1, 0);
    measureOn(n);
    check("R4", "regulated ON ticks", n, REG_T);

    // R2: turn-off, and turn-off winning a tie
    pulse(1, 0); step(3);
    pulse(0, 1);
    check("R2", "gate after turn-off", int'(gateOn), 0);
    pulse(1, 1);
    check("R2", "gate after simultaneous strobes", int'(gateOn), 0);

    // R5: overcurrent forces off, and blocks turn-on
    doReset();
    pulse(1, 0); step(2);
    ocTrip = 1; step(1);
    check("R5", "gate under overcurrent", int'(gateOn), 0);
    pulse(1, 0);
    check("R5", "turn-on during overcurrent", int'(gateOn), 0);
    ocTrip = 0; step(2);

    // R5 / R7: ignored turn-on must not break the turn-off run
    doReset();
    pulse(0, 1); pulse(0, 1);
    ocTrip = 1; pulse(1, 0); ocTrip = 0;
    pulse(0, 1);
    measureShut(0, n);
    check("R5", "delay ticks after ignored turn-on", n, DLY_T);
    check("R7", "shutdown raised", int'(shutdownReq), 1);

    // R8: latched and gate held low
    pulse(1, 0);
    check("R8", "gate after shutdown", int'(gateOn), 0);
    step(60);
    check("R8", "shutdown still latched", int'(shutdownReq), 1);

    // R6: accepted turn-on resets the run
    doReset();
    pulse(0, 1); pulse(0, 1); pulse(1, 0); pulse(0, 1); pulse(0, 1);
    step(400);
    check("R6", "no shutdown after broken run", int'(shutdownReq), 0);
    pulse(0, 1);
    measureShut(1, n);
    check("R7", "delay ticks with extra turn-off", n, DLY_T);

    // R9: disabled
    doReset();
    enable = 0;
    pulse(1, 0);
    check("R9", "gate while disabled", int'(gateOn), 0);
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    step(400);
    check("R9", "no shutdown while disabled", int'(shutdownReq), 0);
    enable = 1;
    step(2);

    // Random traffic against the reference model
    for (int seg = 0; seg < 4; seg++) begin
      doReset();
      regMode = $urandom % 2;
      for (int c = 0; c < 2500; c++) begin
        posPulse = ($urandom % 8 == 0);
        negPulse = ($urandom % 12 == 0);
        ocTrip   = ($urandom % 20 == 0);
        enable   = ($urandom % 50 != 0);
        if ($urandom % 200 == 0) regMode = ~regMode;
        @(negedge clk);
      end
      posPulse = 0; negPulse = 0; ocTrip = 0; enable = 1;
      step(2);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule